// File: doc/BRIEF.md
# Nibble-Stream Ethernet Frame Receiver

This block sits directly behind a 10/100 Ethernet physical layer that delivers its receive path four bits per clock, with a data-valid strobe and a line-error strobe. While data-valid is high it searches for the run of preamble nibbles that ends in the start-of-frame delimiter. Everything after the delimiter is paired into bytes, low nibble first. Each byte is handed to a ready/valid byte port that marks the first and the last byte of the frame.

A frame ends when data-valid falls. At that moment the block takes a single verdict from four inputs: the CRC-32 residue, the received length, nibble alignment and any line error seen inside the frame. The verdict is delivered as a status bit together with the last byte. Each byte is held back by one byte time so that the last-byte marker can be set on the true final byte. The four frame check sequence bytes are passed through like data.

Top module: `nibble_frame_rx`

## Requirements
- R1: Bytes are produced only after data-valid has carried one or more preamble nibbles of value 0x5 followed directly by the nibble 0xD. Data-valid bursts without that delimiter produce no output.
- R2: If a nibble other than 0x5 or 0xD, or a line error, shows up before the delimiter, the rest of that data-valid burst is ignored and no byte comes out.
- R3: After the delimiter, nibble pairs form bytes with the first nibble in bits 3:0 and the second in bits 7:4. The bytes are presented in arrival order, including the four check bytes.
- R4: Within a frame, only the first presented byte carries the first flag and only the final byte carries the last flag. A frame of at least one byte always ends with exactly one last-flagged byte.
- R5: The status bit that comes with the last byte is 1 only if a CRC-32 register over every post-delimiter byte ends at 0xDEBB20E3. The register starts at all ones and shifts LSB first with the reflected polynomial 0xEDB88320 (0x04C11DB7 in normal order).
- R6: A line-error strobe on any nibble inside the frame forces the status bit to 0.
- R7: A frame with fewer than MIN_BYTES (default 64) bytes, check bytes included, gets status 0. A frame of exactly MIN_BYTES bytes with a correct CRC gets status 1.
- R8: A frame that ends on an unpaired nibble gets status 0. The unpaired nibble is not output.
- R9: While valid is high and ready is low, the presented byte and its flags hold. If a new byte has to replace an unaccepted one, the frame gets status 0. The last byte always waits for the sink instead of being replaced.
- R10: During and directly after reset, valid is low.
- R11: A delimiter followed at once by a fall of data-valid produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock from the physical layer |
| rst | input | 1 | Synchronous reset, active high |
| rx_nib | input | NIB_W (4) | Receive nibble |
| rx_dv | input | 1 | Receive data-valid |
| rx_er | input | 1 | Receive line error |
| out_ready | input | 1 | Sink is ready to take a byte |
| out_valid | output | 1 | A byte is presented |
| out_data | output | 2*NIB_W (8) | Presented byte |
| out_first | output | 1 | Byte is the first of its frame |
| out_last | output | 1 | Byte is the last of its frame |
| out_good | output | 1 | Frame verdict, meaningful only with out_last |

## Verification
The bench sends complete frames and checks the received bytes, flags and verdict against a CRC and length model of its own. Frames that differ in one aspect at a time separate the causes of a bad verdict: a corrupted byte, a line error, 63 versus 64 bytes, and a trailing odd nibble. Preambles of length one, bad preamble nibbles and bursts that never reach the delimiter show whether the hunt starts frames only at the right point. Two sink behaviours separate lawful waiting from loss: a ready that toggles every cycle should cost nothing, while a long stall should poison the verdict and still deliver the end marker.

// File: rtl/nrx_pkg.sv
package nrx_pkg;

   typedef enum logic [1:0] {
      HUNT_IDLE,
      HUNT_PRE,
      HUNT_DATA,
      HUNT_DROP
   } hunt_st_t;

   // One byte through a reflected CRC register, LSB first.
   function automatic logic [31:0] crc_step(input logic [31:0] crc_in,
                                            input logic [7:0]  byte_in,
                                            input logic [31:0] poly_r);
      logic [31:0] r;
      r = crc_in ^ {24'd0, byte_in};
      for (int i = 0; i < 8; i++) begin
         r = r[0] ? ((r >> 1) ^ poly_r) : (r >> 1);
      end
      return r;
   endfunction

endpackage

// File: rtl/nrx_hunt.sv
module nrx_hunt
   import nrx_pkg::*;
#(
   parameter int unsigned NIB_W   = 4,
   parameter logic [3:0]  PRE_NIB = 4'h5,
   parameter logic [3:0]  SFD_NIB = 4'hD
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [NIB_W-1:0] rx_nib,
   input  logic             rx_dv,
   input  logic             rx_er,
   output logic             nib_vld,
   output logic             frame_start,
   output logic             frame_end,
   output logic             line_err
);

   hunt_st_t st, st_nxt;

   assign nib_vld     = (st == HUNT_DATA) && rx_dv;
   assign line_err    = nib_vld && rx_er;
   assign frame_end   = (st == HUNT_DATA) && !rx_dv;
   assign frame_start = (st == HUNT_PRE) && rx_dv && !rx_er && (rx_nib == SFD_NIB);

   always_comb begin
      st_nxt = st;
      unique case (st)
         HUNT_IDLE: if (rx_dv) st_nxt = (!rx_er && rx_nib == PRE_NIB) ? HUNT_PRE : HUNT_DROP;
         HUNT_PRE: begin
            if (!rx_dv)                  st_nxt = HUNT_IDLE;
            else if (rx_er)              st_nxt = HUNT_DROP;
            else if (rx_nib == SFD_NIB)  st_nxt = HUNT_DATA;
            else if (rx_nib != PRE_NIB)  st_nxt = HUNT_DROP;
         end
         HUNT_DATA: if (!rx_dv) st_nxt = HUNT_IDLE;
         HUNT_DROP: if (!rx_dv) st_nxt = HUNT_IDLE;
         default:   st_nxt = HUNT_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) st <= HUNT_IDLE;
      else     st <= st_nxt;
   end

   // R1: a frame is entered only from the preamble state
   assert_entry_from_pre_R1: assert property (@(posedge clk) disable iff (rst)
      (st != HUNT_PRE && st != HUNT_DATA) |=> (st != HUNT_DATA));

   // R2: a foreign nibble in the preamble abandons the burst
   assert_bad_pre_drops_R2: assert property (@(posedge clk) disable iff (rst)
      (st == HUNT_PRE && rx_dv && rx_nib != PRE_NIB && rx_nib != SFD_NIB) |=> (st == HUNT_DROP));

endmodule

// File: rtl/nrx_pack.sv
module nrx_pack #(
   parameter int unsigned NIB_W     = 4,
   parameter int unsigned MIN_BYTES = 64
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               frame_start,
   input  logic               nib_vld,
   input  logic [NIB_W-1:0]   nib,
   output logic               byte_vld,
   output logic [2*NIB_W-1:0] byte_data,
   output logic               len_ok,
   output logic               odd_tail
);

   localparam int unsigned      CNT_W   = $clog2(MIN_BYTES + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_BYTES);

   logic             phase;
   logic [NIB_W-1:0] low_nib;
   logic [CNT_W-1:0] cnt;

   assign byte_vld  = nib_vld && phase;
   assign byte_data = {nib, low_nib};
   assign len_ok    = (cnt == CNT_MAX);
   assign odd_tail  = phase;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase   <= 1'b0;
         low_nib <= '0;
         cnt     <= '0;
      end else if (frame_start) begin
         phase <= 1'b0;
         cnt   <= '0;
      end else if (nib_vld) begin
         if (!phase) begin
            low_nib <= nib;
            phase   <= 1'b1;
         end else begin
            phase <= 1'b0;
            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
         end
      end
   end

   // R3: a byte completes only on the second nibble of a pair
   assert_pair_alternates_R3: assert property (@(posedge clk) disable iff (rst)
      byte_vld |=> !phase);

endmodule

// File: rtl/nrx_crc.sv
module nrx_crc
   import nrx_pkg::*;
#(
   parameter bit          CRC_EN      = 1'b1,
   parameter logic [31:0] CRC_POLY_R  = 32'hEDB88320,
   parameter logic [31:0] CRC_RESIDUE = 32'hDEBB20E3
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       frame_start,
   input  logic       byte_vld,
   input  logic [7:0] byte_data,
   output logic       crc_ok
);

   generate
      if (CRC_EN) begin : g_crc
         logic [31:0] crc_q;
         always_ff @(posedge clk) begin
            if (rst || frame_start) crc_q <= '1;
            else if (byte_vld)      crc_q <= crc_step(crc_q, byte_data, CRC_POLY_R);
         end
         assign crc_ok = (crc_q == CRC_RESIDUE);
      end else begin : g_no_crc
         logic unused_in;
         assign unused_in = ^{clk, rst, frame_start, byte_vld, byte_data};
         assign crc_ok    = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/nrx_out.sv
module nrx_out #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              frame_start,
   input  logic              frame_end,
   input  logic              line_err,
   input  logic              byte_vld,
   input  logic [BYTE_W-1:0] byte_data,
   input  logic              crc_ok,
   input  logic              len_ok,
   input  logic              odd_tail,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [BYTE_W-1:0] out_data,
   output logic              out_first,
   output logic              out_last,
   output logic              out_good
);

   logic              pend_vld, pend_first, pend_end, first_due;
   logic [BYTE_W-1:0] pend_data;
   logic              err_seen, ovr_seen, end_good;
   logic              slot_free, push_mid, push_last;

   assign slot_free = !out_valid || out_ready;
   assign push_mid  = byte_vld && pend_vld;
   assign push_last = pend_vld && pend_end && slot_free;

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_vld   <= 1'b0;
         pend_first <= 1'b0;
         pend_end   <= 1'b0;
         pend_data  <= '0;
         first_due  <= 1'b0;
         err_seen   <= 1'b0;
         ovr_seen   <= 1'b0;
         end_good   <= 1'b0;
         out_valid  <= 1'b0;
         out_data   <= '0;
         out_first  <= 1'b0;
         out_last   <= 1'b0;
         out_good   <= 1'b0;
      end else begin
         if (line_err)               err_seen <= 1'b1;
         if (push_mid && !slot_free) ovr_seen <= 1'b1;
         if (frame_end && pend_vld) begin
            pend_end <= 1'b1;
            end_good <= crc_ok && len_ok && !odd_tail && !err_seen && !ovr_seen;
         end
         if (push_last) begin
            pend_vld <= 1'b0;
            pend_end <= 1'b0;
         end
         if (byte_vld) begin
            pend_data  <= byte_data;
            pend_vld   <= 1'b1;
            pend_first <= first_due;
            first_due  <= 1'b0;
         end
         if (frame_start) begin
            first_due <= 1'b1;
            err_seen  <= 1'b0;
            ovr_seen  <= 1'b0;
         end
         if (push_mid || push_last) begin
            out_valid <= 1'b1;
            out_data  <= pend_data;
            out_first <= pend_first;
            out_last  <= push_last;
            out_good  <= push_last && end_good;
         end else if (out_ready) begin
            out_valid <= 1'b0;
         end
      end
   end

   // R4: at most one kind of push per cycle
   assert_one_push_R4: assert property (@(posedge clk) disable iff (rst)
      $onehot0({push_mid, push_last}));

   // R9: a stalled beat stays presented
   assert_stall_keeps_valid_R9: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> out_valid);

   // R9: a stalled beat is not replaced unless a data byte is forced in
   assert_stall_keeps_data_R9: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready && !push_mid) |=> ($stable(out_data) && $stable(out_last)));

   // R6: a line error inside the frame spoils the verdict
   assert_err_spoils_R6: assert property (@(posedge clk) disable iff (rst)
      (frame_end && pend_vld && err_seen) |=> !end_good);

   // R7: an undersized frame is judged bad
   assert_short_spoils_R7: assert property (@(posedge clk) disable iff (rst)
      (frame_end && pend_vld && !len_ok) |=> !end_good);

endmodule

// File: rtl/nibble_frame_rx.sv
module nibble_frame_rx #(
   parameter int unsigned NIB_W       = 4,
   parameter int unsigned MIN_BYTES   = 64,
   parameter logic [3:0]  PRE_NIB     = 4'h5,
   parameter logic [3:0]  SFD_NIB     = 4'hD,
   parameter bit          CRC_EN      = 1'b1,
   parameter logic [31:0] CRC_POLY_R  = 32'hEDB88320,
   parameter logic [31:0] CRC_RESIDUE = 32'hDEBB20E3
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NIB_W-1:0]   rx_nib,
   input  logic               rx_dv,
   input  logic               rx_er,
   input  logic               out_ready,
   output logic               out_valid,
   output logic [2*NIB_W-1:0] out_data,
   output logic               out_first,
   output logic               out_last,
   output logic               out_good
);

   localparam int unsigned BYTE_W = 2 * NIB_W;

   generate
      if (NIB_W != 4) begin : g_chk_nib
         $error("nibble_frame_rx: NIB_W must be 4");
      end
      if (MIN_BYTES < 1) begin : g_chk_min
         $error("nibble_frame_rx: MIN_BYTES must be at least 1");
      end
   endgenerate

   logic              nib_vld, frame_start, frame_end, line_err;
   logic              byte_vld, len_ok, odd_tail, crc_ok;
   logic [BYTE_W-1:0] byte_data;

   nrx_hunt #(.NIB_W(NIB_W), .PRE_NIB(PRE_NIB), .SFD_NIB(SFD_NIB)) u_hunt (
      .clk(clk), .rst(rst), .rx_nib(rx_nib), .rx_dv(rx_dv), .rx_er(rx_er),
      .nib_vld(nib_vld), .frame_start(frame_start), .frame_end(frame_end),
      .line_err(line_err)
   );

   nrx_pack #(.NIB_W(NIB_W), .MIN_BYTES(MIN_BYTES)) u_pack (
      .clk(clk), .rst(rst), .frame_start(frame_start), .nib_vld(nib_vld),
      .nib(rx_nib), .byte_vld(byte_vld), .byte_data(byte_data),
      .len_ok(len_ok), .odd_tail(odd_tail)
   );

   nrx_crc #(.CRC_EN(CRC_EN), .CRC_POLY_R(CRC_POLY_R), .CRC_RESIDUE(CRC_RESIDUE)) u_crc (
      .clk(clk), .rst(rst), .frame_start(frame_start), .byte_vld(byte_vld),
      .byte_data(byte_data[7:0]), .crc_ok(crc_ok)
   );

   nrx_out #(.BYTE_W(BYTE_W)) u_out (
      .clk(clk), .rst(rst), .frame_start(frame_start), .frame_end(frame_end),
      .line_err(line_err), .byte_vld(byte_vld), .byte_data(byte_data),
      .crc_ok(crc_ok), .len_ok(len_ok), .odd_tail(odd_tail),
      .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
      .out_first(out_first), .out_last(out_last), .out_good(out_good)
   );

   // R10: reset clears the byte port
   assert_reset_idle_R10: assert property (@(posedge clk) rst |=> !out_valid);

endmodule

// File: tb/test_nibble_frame_rx.sv
module test_nibble_frame_rx;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] rx_nib = 4'h0;
   logic       rx_dv = 1'b0;
   logic       rx_er = 1'b0;
   logic       out_ready;
   logic       out_valid, out_first, out_last, out_good;
   logic [7:0] out_data;

   always #2 clk = ~clk;

   nibble_frame_rx i_nibble_frame_rx (
      .clk(clk), .rst(rst), .rx_nib(rx_nib), .rx_dv(rx_dv), .rx_er(rx_er),
      .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
      .out_first(out_first), .out_last(out_last), .out_good(out_good)
   );

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   // sink behaviour: 0 always ready, 1 toggling, 2 stall window
   int rdy_mode = 0;
   int stall_lo = 0;
   int stall_hi = 0;

   logic [7:0] fb [0:299];
   int         fn = 0;

   logic [7:0] got_d [0:299];
   bit         got_f [0:299];
   bit         got_l [0:299];
   bit         got_g [0:299];
   int         got_n = 0;
   bit         last_seen = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   always @(posedge clk) begin
      #1;
      case (rdy_mode)
         1:       out_ready = cyc[0];
         2:       out_ready = !(cyc >= stall_lo && cyc < stall_hi);
         default: out_ready = 1'b1;
      endcase
   end

   always @(negedge clk) begin
      if (!rst && out_valid && out_ready) begin
         if (got_n < 300) begin
            got_d[got_n] = out_data;
            got_f[got_n] = out_first;
            got_l[got_n] = out_last;
            got_g[got_n] = out_good;
         end
         got_n = got_n + 1;
         if (out_last) last_seen = 1'b1;
      end
   end

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   always @(posedge clk) begin
      if (cyc == 150000) begin
         n_chk = n_chk + 1;
         n_bad = n_bad + 1;
         $display("FAIL watchdog: run hung, actual cycles %0d expected fewer", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      n_chk = n_chk + 1;
      if (!ok) begin
         n_bad = n_bad + 1;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_crc(input int n);
      logic [31:0] c;
      c = 32'hFFFFFFFF;
      for (int i = 0; i < n; i++) begin
         c = c ^ {24'd0, fb[i]};
         for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
      end
      return c;
   endfunction

   task automatic build(input int n_data, input int seed);
      logic [31:0] fcs;
      for (int i = 0; i < n_data; i++) fb[i] = 8'((i * 37 + seed * 11 + 3) & 255);
      fcs = ~ref_crc(n_data);
      for (int k = 0; k < 4; k++) fb[n_data + k] = fcs[8*k +: 8];
      fn = n_data + 4;
   endtask

   task automatic drive(input logic [3:0] n, input logic dv, input logic er);
      @(posedge clk);
      #1;
      rx_nib = n;
      rx_dv  = dv;
      rx_er  = er;
   endtask

   task automatic clear_rx();
      got_n     = 0;
      last_seen = 1'b0;
   endtask

   task automatic finish_burst();
      drive(4'h0, 1'b0, 1'b0);
      for (int w = 0; w < 80 && !last_seen; w++) @(posedge clk);
      repeat (12) @(posedge clk);
   endtask

   // preamble, delimiter, frame bytes low nibble first, optional error nibble and odd tail
   task automatic send(input int pre_len, input int err_nib, input bit odd_extra);
      clear_rx();
      for (int p = 0; p < pre_len; p++) drive(4'h5, 1'b1, 1'b0);
      drive(4'hD, 1'b1, 1'b0);
      for (int i = 0; i < fn; i++) begin
         drive(fb[i][3:0], 1'b1, (2*i == err_nib));
         drive(fb[i][7:4], 1'b1, (2*i + 1 == err_nib));
      end
      if (odd_extra) drive(4'h3, 1'b1, 1'b0);
      finish_burst();
   endtask

   task automatic check_frame(input string tag, input int exp_n, input bit exp_good);
      int mism;
      int nfirst;
      int nlast;
      chk(got_n == exp_n, "R3", {tag, " byte count"}, got_n, exp_n);
      mism = 0;
      nfirst = 0;
      nlast = 0;
      for (int i = 0; i < got_n && i < exp_n && i < 300; i++) begin
         if (got_d[i] != fb[i]) mism++;
         if (got_f[i]) nfirst++;
         if (got_l[i]) nlast++;
      end
      chk(mism == 0, "R3", {tag, " data mismatches"}, mism, 0);
      chk(got_n > 0 && got_f[0] && nfirst == 1, "R4", {tag, " first flags"}, nfirst, 1);
      chk(got_n > 0 && got_l[got_n-1] && nlast == 1, "R4", {tag, " last flags"}, nlast, 1);
      chk(got_n > 0 && got_g[got_n-1] == exp_good, tag, "verdict",
          (got_n > 0) ? int'(got_g[got_n-1]) : -1, int'(exp_good));
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(out_valid == 1'b0, "R10", "valid in reset", int'(out_valid), 0);
      @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      chk(out_valid == 1'b0, "R10", "valid after reset", int'(out_valid), 0);
   endtask

   task automatic t_good_min();
      build(60, 1);
      send(15, -1, 1'b0);
      check_frame("R5 R7 64-byte good frame", 64, 1'b1);
   endtask

   task automatic t_long_short_pre();
      build(120, 2);
      send(1, -1, 1'b0);
      check_frame("R1 one-nibble preamble", 124, 1'b1);
   endtask

   task automatic t_bad_crc();
      build(60, 3);
      fb[20] = fb[20] ^ 8'h10;
      send(15, -1, 1'b0);
      check_frame("R5 corrupted byte", 64, 1'b0);
   endtask

   task automatic t_line_err();
      build(70, 4);
      send(15, 31, 1'b0);
      check_frame("R6 line error", 74, 1'b0);
   endtask

   task automatic t_short();
      build(59, 5);
      send(15, -1, 1'b0);
      check_frame("R7 63-byte frame", 63, 1'b0);
   endtask

   task automatic t_odd();
      build(60, 6);
      send(15, -1, 1'b1);
      check_frame("R8 odd tail", 64, 1'b0);
   endtask

   task automatic t_no_sfd();
      clear_rx();
      for (int p = 0; p < 20; p++) drive(4'h5, 1'b1, 1'b0);
      finish_burst();
      chk(got_n == 0, "R1", "preamble without delimiter", got_n, 0);
      clear_rx();
      for (int p = 0; p < 6; p++) drive(4'h5, 1'b1, 1'b0);
      drive(4'hD, 1'b1, 1'b0);
      finish_burst();
      chk(got_n == 0, "R11", "delimiter then drop", got_n, 0);
   endtask

   task automatic t_bad_pre();
      build(60, 7);
      clear_rx();
      drive(4'h5, 1'b1, 1'b0);
      drive(4'hA, 1'b1, 1'b0);
      drive(4'h5, 1'b1, 1'b0);
      drive(4'hD, 1'b1, 1'b0);
      for (int i = 0; i < fn; i++) begin
         drive(fb[i][3:0], 1'b1, 1'b0);
         drive(fb[i][7:4], 1'b1, 1'b0);
      end
      finish_burst();
      chk(got_n == 0, "R2", "foreign preamble nibble", got_n, 0);
      clear_rx();
      drive(4'h5, 1'b1, 1'b0);
      drive(4'h5, 1'b1, 1'b1);
      drive(4'hD, 1'b1, 1'b0);
      for (int i = 0; i < fn; i++) begin
         drive(fb[i][3:0], 1'b1, 1'b0);
         drive(fb[i][7:4], 1'b1, 1'b0);
      end
      finish_burst();
      chk(got_n == 0, "R2", "line error in preamble", got_n, 0);
   endtask

   task automatic t_toggle_ready();
      build(64, 8);
      rdy_mode = 1;
      send(15, -1, 1'b0);
      rdy_mode = 0;
      check_frame("R9 toggling ready", 68, 1'b1);
   endtask

   task automatic t_stall();
      build(64, 9);
      stall_lo = cyc + 60;
      stall_hi = cyc + 90;
      rdy_mode = 2;
      send(15, -1, 1'b0);
      rdy_mode = 0;
      chk(got_n > 0 && got_n < 68, "R9", "beats after stall", got_n, 68);
      chk(got_n > 0 && got_l[got_n-1], "R9", "end marker after stall",
          (got_n > 0) ? int'(got_l[got_n-1]) : -1, 1);
      chk(got_n > 0 && !got_g[got_n-1], "R9", "verdict after overwrite",
          (got_n > 0) ? int'(got_g[got_n-1]) : -1, 0);
   endtask

   initial begin
      out_ready = 1'b1;
      t_reset();
      t_good_min();
      t_long_short_pre();
      t_bad_crc();
      t_line_err();
      t_short();
      t_odd();
      t_no_sfd();
      t_bad_pre();
      t_toggle_ready();
      t_stall();
      t_good_min();
      summary();
      $finish;
   end

endmodule